// File: doc/BRIEF.md
# Automatic and Manual Step Clock Selector

This block produces the single clock pulse stream that drives an external quarter-duty generator. That generator splits successive pulses into a primary phase and an inverted phase. In normal running, a free-running automatic clock passes straight through. A single step button serves two purposes: it moves the block into manual mode, and once manual mode is active, each press and each release of that button gives one pulse. A separate auto button returns the block to automatic running at once.

The step button is debounced by sampling. On each scan tick (a one-cycle enable, nominally every 10 ms and adjustable between roughly 50 Hz and 150 Hz) the raw level is loaded into a first register, and the earlier sample moves into a second register. When the two samples differ, the block emits a pulse exactly one tick interval long. The move into manual mode waits for the falling edge of the primary output, which is fed back from the quarter-duty generator. As a result, the automatic clock always finishes a primary pulse before manual stepping starts. The press that caused the switch gives no pulse, and the release that follows lands in the inverted slot.

A four-state controller holds the mode. The states are AUTO, ARMED (press seen, waiting for the primary fall) and MANUAL, plus an unused encoding that recovers to AUTO. The transitions are:
- T_ARM: AUTO to ARMED on a debounced press.
- T_ENTER: ARMED to MANUAL on a primary falling edge while both samples read pressed.
- T_ABORT: ARMED to AUTO when the debounced press is withdrawn.
- T_OVERRIDE: any state to AUTO while the auto button is asserted.

Top module: `clk_mode_ctrl`

## Requirements
- R1: After reset, manual_mode is 0, both button samples read released, and merged_clk equals auto_clk.
- R2: The button is sampled only in cycles where scan_tick is 1. Bounce that ends within one tick interval therefore gives exactly one merged_clk pulse per press or release in manual mode.
- R3: Each manual pulse on merged_clk starts one clock after the tick that captures a changed level. It stays high for exactly one tick interval, until the clock after the next tick.
- R4: While manual_mode is 0 (states AUTO and ARMED), merged_clk equals auto_clk, and press or release pulses have no effect on it.
- R5: manual_mode rises only in the clock after pri_fb is seen falling (1 in the previous cycle, 0 now) while both button samples read pressed.
- R6: The press that brings the block into manual mode produces no pulse. The next pulse comes from the following release.
- R7: While manual_mode is 1, merged_clk carries only the step pulses, and auto_clk has no effect on it.
- R8: An auto_btn level of 1 forces manual_mode to 0 in the next cycle, from any state.
- R9: A press that is released before any primary falling edge returns the block to AUTO, without it ever entering manual mode.
- R10: Across repeated mode switches, with an external divider alternating primary and inverted slots, every manual press lands in a primary slot and every manual release lands in an inverted slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scan_tick | input | 1 | One-cycle enable that marks a button sampling instant |
| auto_clk | input | 1 | Free-running automatic clock level |
| step_btn | input | 1 | Raw step button level, 1 when pressed by default |
| auto_btn | input | 1 | Return-to-automatic button, 1 when pressed by default |
| pri_fb | input | 1 | Primary phase output fed back from the quarter-duty generator |
| merged_clk | output | 1 | Pulse stream toward the quarter-duty generator |
| manual_mode | output | 1 | 1 while manual stepping is in force |

## Verification
The latencies come from the register chain:
- merged_clk follows auto_clk in the same cycle.
- A captured button change reaches merged_clk one clock after its scan tick and holds for one full tick interval.
- A primary falling edge seen on pri_fb moves manual_mode one clock later.
- auto_btn clears manual_mode one clock later.

The bench drives its inputs shortly after each rising edge and updates a behavioural reference at the same edges. It compares both outputs at every falling edge, so each result is read in the cycle it is due. Counts of pulses, slot assignments and high cycles are read only after several full tick intervals have elapsed, so no pending pulse is cut short.

// File: rtl/clk_mode_pkg.sv
package clk_mode_pkg;

    typedef enum logic [1:0] {
        ST_AUTO   = 2'd0,
        ST_ARMED  = 2'd1,
        ST_MANUAL = 2'd2,
        ST_SPARE  = 2'd3
    } mode_state_t;

endpackage

// File: rtl/cmc_step_sampler.sv
module cmc_step_sampler #(
    parameter logic PRESS_LEVEL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scan_tick,
    input  logic btn_raw,
    output logic pressed_new,
    output logic pressed_old,
    output logic step_pulse
);

    logic btn_is_pressed;

    assign btn_is_pressed = (btn_raw == PRESS_LEVEL);

    // Two-stage scan: newest sample and the one before it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pressed_new <= 1'b0;
            pressed_old <= 1'b0;
        end else if (scan_tick) begin
            pressed_new <= btn_is_pressed;
            pressed_old <= pressed_new;
        end
    end

    assign step_pulse = pressed_new ^ pressed_old;

    // R2: the samples move only at scan instants
    a_r2_sample_on_tick : assert property (@(posedge clk) disable iff (!rst_n)
        !scan_tick |=> $stable(pressed_new) && $stable(pressed_old));

    // R3: a pulse can begin or end only after a scan instant
    a_r3_pulse_held : assert property (@(posedge clk) disable iff (!rst_n)
        !scan_tick |=> $stable(step_pulse));

endmodule

// File: rtl/cmc_mode_fsm.sv
module cmc_mode_fsm
    import clk_mode_pkg::*;
#(
    parameter logic AUTO_LEVEL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic auto_btn,
    input  logic pressed_new,
    input  logic pressed_old,
    input  logic pri_fb,
    output logic manual_mode
);

    mode_state_t state_q;
    mode_state_t state_d;
    logic        pri_q;
    logic        pri_fall;
    logic        go_auto;
    logic        held_settled;

    assign go_auto      = (auto_btn == AUTO_LEVEL);
    assign pri_fall     = pri_q & ~pri_fb;
    assign held_settled = pressed_new & pressed_old;

    // Next-state selection with the named transitions.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_AUTO: begin
                if (!go_auto && pressed_new)           state_d = ST_ARMED;  // T_ARM
            end
            ST_ARMED: begin
                if (go_auto)                           state_d = ST_AUTO;   // T_OVERRIDE
                else if (!pressed_new)                 state_d = ST_AUTO;   // T_ABORT
                else if (pri_fall && held_settled)     state_d = ST_MANUAL; // T_ENTER
            end
            ST_MANUAL: begin
                if (go_auto)                           state_d = ST_AUTO;   // T_OVERRIDE
            end
            default:                                   state_d = ST_AUTO;
        endcase
    end

    // State register and primary feedback history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_AUTO;
            pri_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            pri_q   <= pri_fb;
        end
    end

    // Outputs.
    always_comb begin
        manual_mode = (state_q == ST_MANUAL);
    end

    // R5: manual mode starts only right after a primary falling edge
    a_r5_enter_on_fall : assert property (@(posedge clk) disable iff (!rst_n)
        $rose(manual_mode) |-> $past(pri_fall) && $past(held_settled));

    // R8: the auto button wins on the next cycle
    a_r8_override : assert property (@(posedge clk) disable iff (!rst_n)
        go_auto |=> !manual_mode);

    // R9: a withdrawn press never reaches manual mode
    a_r9_no_entry_released : assert property (@(posedge clk) disable iff (!rst_n)
        $rose(manual_mode) |-> $past(pressed_new));

endmodule

// File: rtl/cmc_clk_merge.sv
module cmc_clk_merge (
    input  logic manual_mode,
    input  logic auto_clk,
    input  logic step_pulse,
    output logic merged_clk
);

    always_comb begin
        merged_clk = (auto_clk & ~manual_mode) | (step_pulse & manual_mode);
    end

endmodule

// File: rtl/clk_mode_ctrl.sv
module clk_mode_ctrl #(
    parameter logic STEP_PRESS_LEVEL = 1'b1,
    parameter logic AUTO_PRESS_LEVEL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scan_tick,
    input  logic auto_clk,
    input  logic step_btn,
    input  logic auto_btn,
    input  logic pri_fb,
    output logic merged_clk,
    output logic manual_mode
);

    logic pressed_new;
    logic pressed_old;
    logic step_pulse;

    cmc_step_sampler #(.PRESS_LEVEL(STEP_PRESS_LEVEL)) u_sampler (
        .clk         (clk),
        .rst_n       (rst_n),
        .scan_tick   (scan_tick),
        .btn_raw     (step_btn),
        .pressed_new (pressed_new),
        .pressed_old (pressed_old),
        .step_pulse  (step_pulse)
    );

    cmc_mode_fsm #(.AUTO_LEVEL(AUTO_PRESS_LEVEL)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .auto_btn    (auto_btn),
        .pressed_new (pressed_new),
        .pressed_old (pressed_old),
        .pri_fb      (pri_fb),
        .manual_mode (manual_mode)
    );

    cmc_clk_merge u_merge (
        .manual_mode (manual_mode),
        .auto_clk    (auto_clk),
        .step_pulse  (step_pulse),
        .merged_clk  (merged_clk)
    );

    // R6: the entering press has already ended when manual mode begins
    a_r6_quiet_entry : assert property (@(posedge clk) disable iff (!rst_n)
        $rose(manual_mode) |-> !step_pulse);

    // R7: in manual mode a pulse on the output needs a pending step pulse
    a_r7_manual_source : assert property (@(posedge clk) disable iff (!rst_n)
        (manual_mode && merged_clk) |-> (pressed_new != pressed_old));

endmodule

// File: tb/clk_mode_ctrl_tb.sv
module clk_mode_ctrl_tb;

    localparam int TICK_CYC = 50;
    localparam int AUTO_HALF = 8;
    localparam int WATCHDOG = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scan_tick = 1'b0;
    logic auto_clk = 1'b0;
    logic step_btn = 1'b0;
    logic auto_btn = 1'b0;
    logic pri_fb;
    logic merged_clk;
    logic manual_mode;

    always #10 clk = ~clk;

    clk_mode_ctrl u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .scan_tick   (scan_tick),
        .auto_clk    (auto_clk),
        .step_btn    (step_btn),
        .auto_btn    (auto_btn),
        .pri_fb      (pri_fb),
        .merged_clk  (merged_clk),
        .manual_mode (manual_mode)
    );

    // Stimulus generators: scan tick and automatic clock.
    bit auto_run = 1'b0;
    int tick_cnt = 0;
    int auto_cnt = 0;
    always @(posedge clk) begin
        #3;
        tick_cnt = (tick_cnt == TICK_CYC - 1) ? 0 : tick_cnt + 1;
        scan_tick = (tick_cnt == 0) && rst_n;
        if (auto_run) begin
            auto_cnt = (auto_cnt == 2 * AUTO_HALF - 1) ? 0 : auto_cnt + 1;
            auto_clk = (auto_cnt < AUTO_HALF);
        end else begin
            auto_cnt = 2 * AUTO_HALF - 1;
            auto_clk = 1'b0;
        end
    end

    // Quarter-duty divider stand-in: alternates primary and inverted slots.
    logic m_q, next_pri, cur_pri, pri_r;
    int prim_cnt, inv_cnt, hi_cnt, man_rises;
    assign pri_fb = pri_r;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_q <= 1'b0; next_pri <= 1'b1; cur_pri <= 1'b0; pri_r <= 1'b0;
            prim_cnt <= 0; inv_cnt <= 0; hi_cnt <= 0; man_rises <= 0;
        end else begin
            m_q <= merged_clk;
            if (merged_clk && !m_q) begin
                cur_pri  <= next_pri;
                next_pri <= ~next_pri;
                if (manual_mode) begin
                    man_rises <= man_rises + 1;
                    if (next_pri) prim_cnt <= prim_cnt + 1;
                    else          inv_cnt  <= inv_cnt + 1;
                end
            end
            pri_r <= merged_clk && ((merged_clk && !m_q) ? next_pri : cur_pri);
            if (manual_mode && merged_clk) hi_cnt <= hi_cnt + 1;
        end
    end

    // Behavioural reference: 0 automatic, 1 waiting for primary fall, 2 manual.
    bit r_new, r_old, r_pri;
    int r_mode;
    always @(posedge clk) begin
        if (!rst_n) begin
            r_new <= 0; r_old <= 0; r_pri <= 0; r_mode <= 0;
        end else begin
            if (scan_tick) begin
                r_new <= step_btn;
                r_old <= r_new;
            end
            r_pri <= pri_fb;
            if (auto_btn)                               r_mode <= 0;
            else if (r_mode == 0 && r_new)              r_mode <= 1;
            else if (r_mode == 1 && !r_new)             r_mode <= 0;
            else if (r_mode == 1 && r_pri && !pri_fb && r_new && r_old) r_mode <= 2;
        end
    end

    // Every-cycle comparison.
    int cmp_checks = 0;
    int cmp_fails = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            automatic bit exp_m = (r_mode == 2) ? (r_new ^ r_old) : auto_clk;
            cmp_checks += 2;
            if (merged_clk !== exp_m) begin
                cmp_fails++;
                $display("FAIL %s merged_clk actual=%0d expected=%0d",
                         (r_mode == 2) ? "R7" : "R4", merged_clk, exp_m);
            end
            if (manual_mode !== (r_mode == 2)) begin
                cmp_fails++;
                $display("FAIL R5 manual_mode actual=%0d expected=%0d",
                         manual_mode, (r_mode == 2));
            end
        end
    end

    // Scenario checks.
    int checks = 0;
    int fails = 0;
    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #3;
    endtask

    task automatic wait_ticks(input int n);
        repeat (n * TICK_CYC) step();
    endtask

    // Bounce that starts just after a tick and settles within 20 cycles.
    task automatic bounce_to(input bit lvl);
        do step(); while (!scan_tick);
        step();
        step_btn = lvl;  repeat (3) step();
        step_btn = ~lvl; repeat (4) step();
        step_btn = lvl;  repeat (5) step();
        step_btn = ~lvl; repeat (6) step();
        step_btn = lvl;
    endtask

    task automatic manual_session(input int k);
        int p0, i0, h0, r0, zero_hi;
        bit entered;
        p0 = prim_cnt; i0 = inv_cnt;
        bounce_to(1'b1);
        entered = 0;
        for (int c = 0; c < 6 * TICK_CYC; c++) begin
            step();
            if (manual_mode) begin entered = 1; break; end
        end
        chk(entered, "R5 entry", entered, 1);
        wait_ticks(2);
        chk(prim_cnt == p0 && inv_cnt == i0, "R6 no pulse from entering press",
            prim_cnt - p0 + inv_cnt - i0, 0);
        h0 = hi_cnt; r0 = man_rises;
        bounce_to(1'b0);
        wait_ticks(3);
        chk(inv_cnt == i0 + 1, "R10 release in inverted slot", inv_cnt - i0, 1);
        chk(hi_cnt - h0 == TICK_CYC, "R3 pulse width", hi_cnt - h0, TICK_CYC);
        chk(man_rises - r0 == 1, "R2 one pulse per bouncing release", man_rises - r0, 1);
        r0 = man_rises;
        bounce_to(1'b1);
        wait_ticks(3);
        chk(prim_cnt == p0 + 1, "R10 press in primary slot", prim_cnt - p0, 1);
        chk(man_rises - r0 == 1, "R2 one pulse per bouncing press", man_rises - r0, 1);
        zero_hi = 0;
        for (int c = 0; c < 60; c++) begin
            @(negedge clk);
            if (merged_clk) zero_hi++;
        end
        chk(zero_hi == 0, "R7 auto clock blocked in manual", zero_hi, 0);
        bounce_to(1'b0);
        wait_ticks(3);
        chk(inv_cnt == i0 + 2, "R10 second release inverted", inv_cnt - i0, 2);
        auto_btn = 1'b1;
        step();
        auto_btn = 1'b0;
        @(negedge clk);
        chk(!manual_mode, "R8 override", manual_mode, 0);
        chk(merged_clk == auto_clk, "R4 auto clock restored", merged_clk, auto_clk);
        step();
        wait_ticks(1);
        if (k < 0) $display("session %0d", k);
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures",
                     checks + cmp_checks + 1, fails + cmp_fails + 1);
            $finish;
        end
    end

    initial begin
        int hi_auto;
        repeat (4) step();
        @(negedge clk);
        chk(!manual_mode, "R1 reset mode", manual_mode, 0);
        chk(merged_clk == auto_clk, "R1 reset merged", merged_clk, auto_clk);
        step();
        rst_n = 1'b1;
        @(negedge clk);
        chk(!manual_mode, "R1 mode after release", manual_mode, 0);

        // R9: press and release with the automatic clock stopped.
        bounce_to(1'b1);
        wait_ticks(3);
        chk(!manual_mode, "R9 held without primary fall", manual_mode, 0);
        hi_auto = 0;
        bounce_to(1'b0);
        for (int c = 0; c < 3 * TICK_CYC; c++) begin
            @(negedge clk);
            if (merged_clk) hi_auto++;
        end
        chk(hi_auto == 0, "R4 step pulses ignored in auto", hi_auto, 0);
        auto_run = 1'b1;
        wait_ticks(2);
        chk(!manual_mode, "R9 stays automatic after early release", manual_mode, 0);

        for (int k = 0; k < 3; k++) manual_session(k);

        // Override during the wait for a primary fall.
        bounce_to(1'b1);
        auto_btn = 1'b1;
        wait_ticks(3);
        chk(!manual_mode, "R8 held override blocks entry", manual_mode, 0);
        bounce_to(1'b0);
        wait_ticks(2);
        auto_btn = 1'b0;
        wait_ticks(1);
        chk(!manual_mode, "R8 remains automatic", manual_mode, 0);

        $display("End of test - %0d assertions evaluated, %0d failures",
                 checks + cmp_checks, fails + cmp_fails);
        $finish;
    end

endmodule